// File: doc/BRIEF.md
# Video DAC Host Command Registers

This block sits on the host side of a true-colour video DAC. The host addresses it through a 4-bit register select. Two address lines form the low bits of that select, and two extra select pins form the high bits. On a write or read strobe the block decodes the select. Command, cursor-position and configuration registers are handled locally.

Palette ports, overlay colour data and cursor RAM data are handed on to companion blocks through dedicated strobes, and their read data comes back through this block's read multiplexer. From the stored registers the block derives the pixel depth, the palette DAC width, the hardware-cursor enable and the cursor size. It also raises a one-cycle pulse whenever a write changes the pixel depth or the cursor size, so that display timing can be recomputed.

A parameter selects between the base chip variant and the later variant. The later variant reaches a fourth command register through the shared palette index pointer.

Top module: `vdac_cmd_regs`

## Requirements
- R1: The select is {sel_ext_i[1], sel_ext_i[0], sel_addr_i[1], sel_addr_i[0]}. Selects 0x0..0x4 and 0x7 drive pal_wr_o/pal_rd_o, select 0x5 drives ovl_wr_o/ovl_rd_o, and select 0xB drives cram_wr_o/cram_rd_o. Each strobe follows wr_i/rd_i in the same cycle, and for these selects rdata_o returns the matching companion read-data input.
- R2: Select 0x6 holds command register 0, which reads back as written. Its bit 0 drives dac8_o (1 = 8-bit palette DAC, 0 = 6-bit).
- R3: Selects 0x8 and 0x9 hold command registers 1 and 2, which read back as written.
- R4: While bit 7 of command register 0 is clear, a write to select 0xA changes nothing. A read of select 0xA returns 0x60 when VARIANT_A=0 and 0x20 when VARIANT_A=1.
- R5: With VARIANT_A=0 and bit 7 of command register 0 set, select 0xA reads and writes command register 3, whatever the value of ptr_i.
- R6: With VARIANT_A=1 and bit 7 of command register 0 set, select 0xA reaches command register 3 when ptr_i=1 and command register 4 when ptr_i=2. With any other ptr_i value a write is ignored and a read returns 0xFF.
- R7: bpp_o is 8 when bit 5 of command register 2 is clear. Otherwise it is decoded from bits 6:5 of command register 1: 00 gives 32, 01 gives 16 if bit 3 is set and 15 if it is clear, 10 gives 8, and 11 gives 4.
- R8: cursor_en_o is 1 whenever bits 1:0 of command register 2 are not both zero. cursor_big_o follows bit 2 of command register 3 (1 = 64x64 cursor, 0 = 32x32).
- R9: Selects 0xC/0xD hold the low byte and high nibble of a 12-bit cursor X position, and selects 0xE/0xF do the same for cursor Y. A high write keeps bits 3:0 of the data. A high read returns the nibble with bits 7:4 zero. The positions appear on cursor_x_o and cursor_y_o.
- R10: After reset every register is zero: dac8_o=0, bpp_o=8, cursor_en_o=0, cursor_big_o=0 and timing_chg_o=0.
- R11: timing_chg_o is high for exactly the one cycle that follows a write edge which changes bpp_o or cursor_big_o. It stays low after a write that changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_addr_i | input | 2 | Low two bits of the register select |
| sel_ext_i | input | 2 | High two bits of the register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| ptr_i | input | PTR_W | Shared palette index pointer |
| pal_rdata_i | input | 8 | Read data from palette logic |
| ovl_rdata_i | input | 8 | Read data from overlay colour logic |
| cram_rdata_i | input | 8 | Read data from cursor RAM |
| rdata_o | output | 8 | Read data for the current select |
| pal_wr_o | output | 1 | Palette port write strobe |
| pal_rd_o | output | 1 | Palette port read strobe |
| ovl_wr_o | output | 1 | Overlay colour write strobe |
| ovl_rd_o | output | 1 | Overlay colour read strobe |
| cram_wr_o | output | 1 | Cursor RAM write strobe |
| cram_rd_o | output | 1 | Cursor RAM read strobe |
| dac8_o | output | 1 | Palette DAC width, 1 = 8-bit |
| bpp_o | output | 6 | Pixel depth in bits |
| cursor_en_o | output | 1 | Hardware cursor enable |
| cursor_big_o | output | 1 | Cursor size, 1 = 64x64 |
| cursor_x_o | output | POS_W | Cursor X position |
| cursor_y_o | output | POS_W | Cursor Y position |
| timing_chg_o | output | 1 | One-cycle pulse on a depth or cursor-size change |

## Verification
All state is readable combinationally, so a corrupted register shows on rdata_o as soon as its select is presented. A wrong derived mode shows on bpp_o, dac8_o or the cursor outputs within the cycle after the write edge. A faulty gate on select 0xA shows as a wrong identification byte, or as a register that moved when it should have stayed, visible on the next read. A mis-timed or missing change pulse is caught by sampling timing_chg_o in the single cycle after each write.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  localparam logic [3:0] SEL_OVL  = 4'h5;
  localparam logic [3:0] SEL_CMD0 = 4'h6;
  localparam logic [3:0] SEL_CMD1 = 4'h8;
  localparam logic [3:0] SEL_CMD2 = 4'h9;
  localparam logic [3:0] SEL_CMD3 = 4'hA;
  localparam logic [3:0] SEL_CRAM = 4'hB;
  localparam logic [3:0] SEL_CXL  = 4'hC;

  typedef struct packed {
    logic pal;
    logic ovl;
    logic cram;
    logic local_reg;
  } region_t;

  function automatic logic [5:0] pixel_depth(input logic [7:0] c1, input logic [7:0] c2);
    if (!c2[5]) return 6'd8;
    case (c1[6:5])
      2'b00:   return 6'd32;
      2'b01:   return c1[3] ? 6'd16 : 6'd15;
      2'b10:   return 6'd8;
      default: return 6'd4;
    endcase
  endfunction
endpackage

// File: rtl/vdac_decode.sv
module vdac_decode
  import vdac_pkg::*;
(
  input  logic [3:0] sel_i,
  output region_t    region_o
);
  always_comb begin
    region_o = '0;
    if (sel_i <= 4'h4 || sel_i == 4'h7) region_o.pal = 1'b1;
    else if (sel_i == SEL_OVL)          region_o.ovl = 1'b1;
    else if (sel_i == SEL_CRAM)         region_o.cram = 1'b1;
    else                                region_o.local_reg = 1'b1;
  end
endmodule

// File: rtl/vdac_cmd_file.sv
module vdac_cmd_file
  import vdac_pkg::*;
#(
  parameter bit VARIANT_A = 1'b0,
  parameter int PTR_W     = 2,
  parameter int POS_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       sel_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [7:0]       cr0_o,
  output logic [7:0]       cr1_o,
  output logic [7:0]       cr2_o,
  output logic [7:0]       cr3_o,
  output logic [POS_W-1:0] cur_x_o,
  output logic [POS_W-1:0] cur_y_o,
  output logic [7:0]       rdata_o
);
  localparam int          HI_W    = POS_W - 8;
  localparam logic [7:0]  ID_BYTE = VARIANT_A ? 8'h20 : 8'h60;

  logic [7:0] cr0_q, cr1_q, cr2_q, cr3_q, cr4_q;
  logic [1:0][POS_W-1:0] pos_q;
  logic gate_open, cr3_hit, cr4_hit;

  assign gate_open = cr0_q[7];
  assign cr3_hit   = gate_open && (!VARIANT_A || ptr_i == PTR_W'(1));
  assign cr4_hit   = gate_open && VARIANT_A && ptr_i == PTR_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q <= '0;
      cr1_q <= '0;
      cr2_q <= '0;
      cr3_q <= '0;
      cr4_q <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_CMD0: cr0_q <= wdata_i;
        SEL_CMD1: cr1_q <= wdata_i;
        SEL_CMD2: cr2_q <= wdata_i;
        SEL_CMD3: begin
          if (cr3_hit)      cr3_q <= wdata_i;
          else if (cr4_hit) cr4_q <= wdata_i;
        end
        default: ;
      endcase
    end
  end

  // one low/high register pair per axis
  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam logic [3:0] SEL_LO = SEL_CXL + 4'(2 * g);
    localparam logic [3:0] SEL_HI = SEL_LO + 4'd1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q[g] <= '0;
      else if (we_i && sel_i == SEL_LO) pos_q[g][7:0] <= wdata_i;
      else if (we_i && sel_i == SEL_HI) pos_q[g][POS_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CMD0: rdata_o = cr0_q;
      SEL_CMD1: rdata_o = cr1_q;
      SEL_CMD2: rdata_o = cr2_q;
      SEL_CMD3: begin
        if (!gate_open)   rdata_o = ID_BYTE;
        else if (cr3_hit) rdata_o = cr3_q;
        else if (cr4_hit) rdata_o = cr4_q;
        else              rdata_o = 8'hFF;
      end
      4'hC:    rdata_o = pos_q[0][7:0];
      4'hD:    rdata_o = 8'(pos_q[0][POS_W-1:8]);
      4'hE:    rdata_o = pos_q[1][7:0];
      4'hF:    rdata_o = 8'(pos_q[1][POS_W-1:8]);
      default: rdata_o = 8'hFF;
    endcase
  end

  assign cr0_o   = cr0_q;
  assign cr1_o   = cr1_q;
  assign cr2_o   = cr2_q;
  assign cr3_o   = cr3_q;
  assign cur_x_o = pos_q[0];
  assign cur_y_o = pos_q[1];

  p_gate_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CMD3 && !cr0_q[7]) |=> ($stable(cr3_q) && $stable(cr4_q)));

  p_ptr_other_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (VARIANT_A && we_i && sel_i == SEL_CMD3 && ptr_i != PTR_W'(1) && ptr_i != PTR_W'(2))
    |=> $stable(cr3_q));

  p_base_ptr_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!VARIANT_A && we_i && sel_i == SEL_CMD3 && cr0_q[7]) |=> (cr3_q == $past(wdata_i)));
endmodule

// File: rtl/vdac_mode_derive.sv
module vdac_mode_derive
  import vdac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cr0_i,
  input  logic [7:0] cr1_i,
  input  logic [7:0] cr2_i,
  input  logic [7:0] cr3_i,
  output logic       dac8_o,
  output logic [5:0] bpp_o,
  output logic       cur_en_o,
  output logic       cur_big_o,
  output logic       chg_o
);
  logic [5:0] bpp_prev_q;
  logic       big_prev_q;

  assign dac8_o    = cr0_i[0];
  assign bpp_o     = pixel_depth(cr1_i, cr2_i);
  assign cur_en_o  = |cr2_i[1:0];
  assign cur_big_o = cr3_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpp_prev_q <= 6'd8;
      big_prev_q <= 1'b0;
    end else begin
      bpp_prev_q <= bpp_o;
      big_prev_q <= cur_big_o;
    end
  end

  assign chg_o = (bpp_o != bpp_prev_q) || (cur_big_o != big_prev_q);

  p_pulse_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (bpp_o != $past(bpp_o) || cur_big_o != $past(cur_big_o)));

  p_depth_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpp_o == 6'd4 || bpp_o == 6'd8 || bpp_o == 6'd15 || bpp_o == 6'd16 || bpp_o == 6'd32));
endmodule

// File: rtl/vdac_cmd_regs.sv
module vdac_cmd_regs
  import vdac_pkg::*;
#(
  parameter bit VARIANT_A = 1'b0,
  parameter int PTR_W     = 2,
  parameter int POS_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_addr_i,
  input  logic [1:0]       sel_ext_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       pal_rdata_i,
  input  logic [7:0]       ovl_rdata_i,
  input  logic [7:0]       cram_rdata_i,
  output logic [7:0]       rdata_o,
  output logic             pal_wr_o,
  output logic             pal_rd_o,
  output logic             ovl_wr_o,
  output logic             ovl_rd_o,
  output logic             cram_wr_o,
  output logic             cram_rd_o,
  output logic             dac8_o,
  output logic [5:0]       bpp_o,
  output logic             cursor_en_o,
  output logic             cursor_big_o,
  output logic [POS_W-1:0] cursor_x_o,
  output logic [POS_W-1:0] cursor_y_o,
  output logic             timing_chg_o
);
  logic [3:0] sel;
  region_t    region;
  logic [7:0] cr0, cr1, cr2, cr3, loc_rdata;

  assign sel = {sel_ext_i, sel_addr_i};

  vdac_decode u_decode (
    .sel_i    (sel),
    .region_o (region)
  );

  vdac_cmd_file #(
    .VARIANT_A (VARIANT_A),
    .PTR_W     (PTR_W),
    .POS_W     (POS_W)
  ) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && region.local_reg),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .ptr_i   (ptr_i),
    .cr0_o   (cr0),
    .cr1_o   (cr1),
    .cr2_o   (cr2),
    .cr3_o   (cr3),
    .cur_x_o (cursor_x_o),
    .cur_y_o (cursor_y_o),
    .rdata_o (loc_rdata)
  );

  vdac_mode_derive u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cr0_i     (cr0),
    .cr1_i     (cr1),
    .cr2_i     (cr2),
    .cr3_i     (cr3),
    .dac8_o    (dac8_o),
    .bpp_o     (bpp_o),
    .cur_en_o  (cursor_en_o),
    .cur_big_o (cursor_big_o),
    .chg_o     (timing_chg_o)
  );

  assign pal_wr_o  = wr_i && region.pal;
  assign pal_rd_o  = rd_i && region.pal;
  assign ovl_wr_o  = wr_i && region.ovl;
  assign ovl_rd_o  = rd_i && region.ovl;
  assign cram_wr_o = wr_i && region.cram;
  assign cram_rd_o = rd_i && region.cram;

  always_comb begin
    if (region.pal)       rdata_o = pal_rdata_i;
    else if (region.ovl)  rdata_o = ovl_rdata_i;
    else if (region.cram) rdata_o = cram_rdata_i;
    else                  rdata_o = loc_rdata;
  end

  p_strobe_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i) |-> $onehot0({pal_wr_o, pal_rd_o, ovl_wr_o, ovl_rd_o, cram_wr_o, cram_rd_o}));

  p_dac_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac8_o) |-> $past(wr_i && sel == SEL_CMD0));

  p_cursor_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel >= SEL_CXL) |=> ($stable(cursor_x_o) && $stable(cursor_y_o)));
endmodule

// File: tb/vdac_cmd_regs_test.sv
module vdac_cmd_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [1:0] ptr = '0;
  logic [7:0] rdata, rdata_a;
  logic pal_wr, pal_rd, ovl_wr, ovl_rd, cram_wr, cram_rd;
  logic pal_wr_a, pal_rd_a, ovl_wr_a, ovl_rd_a, cram_wr_a, cram_rd_a;
  logic dac8, dac8_a, cen, cen_a, big, big_a, chg, chg_a;
  logic [5:0] bpp, bpp_a;
  logic [11:0] cx, cy, cx_a, cy_a;
  int n_chk = 0, n_bad = 0;
  logic p_seen, p_seen_a;

  always #4 clk = ~clk;

  vdac_cmd_regs #(.VARIANT_A(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_addr_i(sel[1:0]), .sel_ext_i(sel[3:2]),
    .wr_i(wr), .rd_i(rd), .wdata_i(wd), .ptr_i(ptr),
    .pal_rdata_i(8'hA5), .ovl_rdata_i(8'h3C), .cram_rdata_i(8'h96),
    .rdata_o(rdata), .pal_wr_o(pal_wr), .pal_rd_o(pal_rd), .ovl_wr_o(ovl_wr),
    .ovl_rd_o(ovl_rd), .cram_wr_o(cram_wr), .cram_rd_o(cram_rd), .dac8_o(dac8),
    .bpp_o(bpp), .cursor_en_o(cen), .cursor_big_o(big), .cursor_x_o(cx),
    .cursor_y_o(cy), .timing_chg_o(chg));

  vdac_cmd_regs #(.VARIANT_A(1'b1)) uut_a (
    .clk_i(clk), .rst_ni(rst_n), .sel_addr_i(sel[1:0]), .sel_ext_i(sel[3:2]),
    .wr_i(wr), .rd_i(rd), .wdata_i(wd), .ptr_i(ptr),
    .pal_rdata_i(8'hA5), .ovl_rdata_i(8'h3C), .cram_rdata_i(8'h96),
    .rdata_o(rdata_a), .pal_wr_o(pal_wr_a), .pal_rd_o(pal_rd_a), .ovl_wr_o(ovl_wr_a),
    .ovl_rd_o(ovl_rd_a), .cram_wr_o(cram_wr_a), .cram_rd_o(cram_rd_a), .dac8_o(dac8_a),
    .bpp_o(bpp_a), .cursor_en_o(cen_a), .cursor_big_o(big_a), .cursor_x_o(cx_a),
    .cursor_y_o(cy_a), .timing_chg_o(chg_a));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // write; records the change pulse in the cycle after the write edge
  task automatic wr_reg(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    p_seen = chg; p_seen_a = chg_a;
  endtask

  task automatic rd_reg(input logic [3:0] s, output logic [7:0] v, output logic [7:0] va);
    @(negedge clk);
    sel = s; rd = 1'b1;
    #1;
    v = rdata; va = rdata_a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v, va;
    chk("R10 dac8", dac8, 0);
    chk("R10 bpp", bpp, 8);
    chk("R10 cursor_en", cen, 0);
    chk("R10 cursor_big", big, 0);
    chk("R10 chg", chg, 0);
    rd_reg(4'h6, v, va);
    chk("R10 cmd0", v, 0);
    rd_reg(4'h9, v, va);
    chk("R10 cmd2", va, 0);
  endtask

  task automatic t_decode;
    logic [7:0] v, va;
    @(negedge clk);
    sel = 4'h3; rd = 1'b1; #1;
    chk("R1 pal_rd", {pal_rd, ovl_rd, cram_rd}, 3'b100);
    chk("R1 pal data", rdata, 8'hA5);
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
    sel = 4'h5; wr = 1'b1; wd = 8'h11; #1;
    chk("R1 ovl_wr", {pal_wr, ovl_wr, cram_wr}, 3'b010);
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    sel = 4'hB; wr = 1'b1; #1;
    chk("R1 cram_wr", {pal_wr_a, ovl_wr_a, cram_wr_a}, 3'b001);
    @(negedge clk); wr = 1'b0;
    rd_reg(4'h5, v, va);
    chk("R1 ovl data", v, 8'h3C);
    rd_reg(4'hB, v, va);
    chk("R1 cram data", va, 8'h96);
    rd_reg(4'h7, v, va);
    chk("R1 sel7 pal data", v, 8'hA5);
  endtask

  task automatic t_cmd;
    logic [7:0] v, va;
    wr_reg(4'h6, 8'h01);
    chk("R2 dac8", dac8, 1);
    rd_reg(4'h6, v, va);
    chk("R2 cmd0 read", v, 8'h01);
    wr_reg(4'h8, 8'h9A);
    rd_reg(4'h8, v, va);
    chk("R3 cmd1 read", v, 8'h9A);
    wr_reg(4'h9, 8'h14);
    rd_reg(4'h9, v, va);
    chk("R3 cmd2 read", va, 8'h14);
    wr_reg(4'h8, 8'h00);
    wr_reg(4'h9, 8'h00);
  endtask

  task automatic t_gate_closed;
    logic [7:0] v, va;
    wr_reg(4'hA, 8'hFF);
    chk("R4 no size change", {big, big_a, p_seen}, 3'b000);
    rd_reg(4'hA, v, va);
    chk("R4 id base", v, 8'h60);
    chk("R4 id variant", va, 8'h20);
  endtask

  task automatic t_gate_open;
    logic [7:0] v, va;
    wr_reg(4'h6, 8'h81);
    ptr = 2'd0;
    wr_reg(4'hA, 8'h04);
    chk("R5 base cmd3 big", big, 1);
    chk("R11 size pulse", p_seen, 1);
    chk("R6 variant ptr0 ignored", {big_a, p_seen_a}, 2'b00);
    rd_reg(4'hA, v, va);
    chk("R5 base cmd3 read", v, 8'h04);
    chk("R6 variant ptr0 read", va, 8'hFF);
    ptr = 2'd1;
    wr_reg(4'hA, 8'h04);
    chk("R8 variant big", big_a, 1);
    ptr = 2'd2;
    wr_reg(4'hA, 8'h33);
    rd_reg(4'hA, v, va);
    chk("R6 variant cmd4 read", va, 8'h33);
    chk("R5 base ignores ptr", v, 8'h33);
    chk("R6 cmd4 keeps size", big_a, 1);
    ptr = 2'd1;
    rd_reg(4'hA, v, va);
    chk("R6 variant cmd3 read", va, 8'h04);
    ptr = 2'd0;
  endtask

  task automatic t_depth;
    wr_reg(4'h8, 8'h00);
    wr_reg(4'h9, 8'h20);
    chk("R7 depth 32", bpp, 32);
    chk("R11 depth pulse", p_seen, 1);
    wr_reg(4'h8, 8'h20);
    chk("R7 depth 15", bpp, 15);
    wr_reg(4'h8, 8'h28);
    chk("R7 depth 16", bpp_a, 16);
    wr_reg(4'h8, 8'h40);
    chk("R7 depth 8", bpp, 8);
    wr_reg(4'h8, 8'h60);
    chk("R7 depth 4", bpp, 4);
    @(negedge clk);
    chk("R11 pulse one cycle", chg, 0);
    wr_reg(4'h8, 8'h60);
    chk("R11 no pulse on same", p_seen, 0);
    wr_reg(4'h9, 8'h00);
    chk("R7 gate clear 8", bpp, 8);
  endtask

  task automatic t_cursor;
    logic [7:0] v, va;
    wr_reg(4'h9, 8'h01);
    chk("R8 en bit0", cen, 1);
    chk("R11 en no pulse", p_seen, 0);
    wr_reg(4'h9, 8'h02);
    chk("R8 en bit1", cen_a, 1);
    wr_reg(4'h9, 8'h00);
    chk("R8 en off", cen, 0);
    wr_reg(4'hC, 8'hAB);
    wr_reg(4'hD, 8'hF7);
    chk("R9 x", cx, 12'h7AB);
    rd_reg(4'hD, v, va);
    chk("R9 x high read", v, 8'h07);
    wr_reg(4'hE, 8'h12);
    wr_reg(4'hF, 8'h3C);
    chk("R9 y", cy_a, 12'hC12);
    rd_reg(4'hE, v, va);
    chk("R9 y low read", v, 8'h12);
    chk("R9 x unchanged", cx, 12'h7AB);
  endtask

  initial begin
    fork
      begin
        #5 rst_n = 1'b1;
        t_reset();
        t_decode();
        t_cmd();
        t_gate_closed();
        t_gate_open();
        t_depth();
        t_cursor();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule